// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block holds the working registers of a small 8-bit processor: four banks of eight byte-wide registers, 32 bytes in all. A bank-select register, loaded from a dedicated input in place of a bank-switch instruction, picks which bank the processor-side ports address. Two processor-side ports exist. The byte port names one of registers 0 to 7 of the active bank. The pair port names one of pairs 0 to 3 of the active bank. Pair p joins register 2p+1 as the high byte with register 2p as the low byte.

A third port reaches the same 32 bytes as data memory through a fixed 32-byte address window starting at FEE0h. This port ignores the bank select. Bank 3 sits at the bottom of the window and bank 0 at the top. Inside a bank, register numbers rise with the address. All reads are combinational. Every write lands on the rising clock edge. When two ports write the same byte in one cycle, a fixed priority decides which value is kept.

Top module: `gpr_bank_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all 32 bytes to 00h and sets the active bank to 0.
- R2: A byte-port write (r8_we high) stores r8_wdata at the next rising edge into register r8_idx of the active bank. r8_rdata shows that register combinationally.
- R3: rp_rdata always equals {register 2*rp_idx+1, register 2*rp_idx} of the active bank.
- R4: A pair-port write stores rp_wdata[15:8] into register 2*rp_idx+1 and rp_wdata[7:0] into register 2*rp_idx, both at the same edge.
- R5: When bank_load is high at a rising edge, active_bank takes bank_in. From the next cycle on, every byte-port and pair-port read and write uses the new bank.
- R6: mem_hit is 1 exactly when mem_addr lies in FEE0h..FEFFh. Outside that range mem_rdata is 00h.
- R7: Inside the window, an address selects bank 3 - mem_addr[4:3] and register mem_addr[2:0], whatever the active bank. The memory port reads and writes the same bytes as the processor-side ports.
- R8: A memory-port write to an address outside the window changes no stored byte.
- R9: If a processor-side write and a memory-port write target the same byte in one cycle, the processor-side value is stored. Writes to different bytes in the same cycle all take effect.
- R10: If a byte-port write and a pair-port write target the same byte in one cycle, the byte-port value is stored. The other byte of the pair still takes the pair value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_load | input | 1 | Load bank_in into the bank-select register |
| bank_in | input | 2 | New bank number |
| active_bank | output | 2 | Current bank-select value |
| r8_idx | input | 3 | Register number within the active bank |
| r8_we | input | 1 | Byte-port write enable |
| r8_wdata | input | 8 | Byte-port write data |
| r8_rdata | output | 8 | Byte-port read data |
| rp_idx | input | 2 | Pair number within the active bank |
| rp_we | input | 1 | Pair-port write enable |
| rp_wdata | input | 16 | Pair write data, high byte to the odd register |
| rp_rdata | output | 16 | Pair read data |
| mem_addr | input | 16 | Data-memory address |
| mem_we | input | 1 | Memory-port write enable |
| mem_wdata | input | 8 | Memory-port write data |
| mem_rdata | output | 8 | Memory-port read data, zero outside the window |
| mem_hit | output | 1 | Address lies inside the register window |

## Verification
Two collisions can happen in a single cycle. The first is a processor-side write and a memory-port write landing on the same byte. The second is a byte-port write overlapping one half of a pair write. The bench sets up each collision by driving both writes on one edge. It picks the memory address from the inverted bank mapping so that it aliases the chosen register, and it picks the byte index inside the targeted pair for the second case. It judges the result by reading the byte back through the other port in the following cycle, and by confirming that the bytes not involved in the collision took their own values.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int NBANK  = 4;
  localparam int NREG   = 8;
  localparam int DW     = 8;
  localparam int BANK_W = $clog2(NBANK);
  localparam int REG_W  = $clog2(NREG);
  localparam int PAIR_W = REG_W - 1;
  localparam int NBYTE  = NBANK * NREG;
  localparam int BYTE_W = $clog2(NBYTE);

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [PAIR_W-1:0] pair_t;
  typedef logic [BYTE_W-1:0] byte_idx_t;
  typedef logic [DW-1:0]     data_t;

  // flat byte index of a register inside a bank
  function automatic byte_idx_t flat_idx(bank_t b, reg_t r);
    return {b, r};
  endfunction

  // flat index of the low (even) byte of a pair
  function automatic byte_idx_t pair_lo(bank_t b, pair_t p);
    return {b, p, 1'b0};
  endfunction

  // banks are stacked downward: the lowest window slot holds the last bank
  function automatic bank_t win_bank(bank_t slot);
    return bank_t'(NBANK - 1) - slot;
  endfunction
endpackage

// File: rtl/gpr_win_decode.sv
module gpr_win_decode
  import gpr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEE0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output byte_idx_t         idx
);
  logic [ADDR_W-1:0] off;

  assign off = addr - WIN_BASE;
  assign hit = (addr >= WIN_BASE) && (off < ADDR_W'(NBYTE));
  assign idx = {win_bank(off[BYTE_W-1:REG_W]), off[REG_W-1:0]};
endmodule

// File: rtl/gpr_write_arb.sv
module gpr_write_arb
  import gpr_pkg::*;
(
  input  byte_idx_t                 r8_tgt,
  input  logic                      r8_we,
  input  data_t                     r8_wdata,
  input  byte_idx_t                 rp_tgt,
  input  logic                      rp_we,
  input  logic [2*DW-1:0]           rp_wdata,
  input  byte_idx_t                 mem_tgt,
  input  logic                      mem_we,
  input  logic                      mem_hit,
  input  data_t                     mem_wdata,
  output logic [NBYTE-1:0]          byte_we,
  output logic [NBYTE-1:0][DW-1:0]  byte_wd,
  output logic                      collide_rm,
  output logic                      collide_rp
);
  logic mem_go;
  byte_idx_t rp_hi_tgt;

  assign mem_go    = mem_we && mem_hit;
  assign rp_hi_tgt = {rp_tgt[BYTE_W-1:1], 1'b1};

  // named collision events for the checker
  assign collide_rm = r8_we && mem_go && (r8_tgt == mem_tgt);
  assign collide_rp = r8_we && rp_we && (r8_tgt[BYTE_W-1:1] == rp_tgt[BYTE_W-1:1]);

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    localparam byte_idx_t ID = byte_idx_t'(i);
    logic by_r8, by_lo, by_hi, by_mem;
    assign by_r8  = r8_we && (r8_tgt == ID);
    assign by_lo  = rp_we && (rp_tgt == ID);
    assign by_hi  = rp_we && (rp_hi_tgt == ID);
    assign by_mem = mem_go && (mem_tgt == ID);
    assign byte_we[i] = by_r8 || by_lo || by_hi || by_mem;
    // priority: byte port, then pair port, then memory port
    assign byte_wd[i] = by_r8 ? r8_wdata :
                        by_lo ? rp_wdata[DW-1:0] :
                        by_hi ? rp_wdata[2*DW-1:DW] : mem_wdata;
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import gpr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NBYTE-1:0]         byte_we,
  input  logic [NBYTE-1:0][DW-1:0] byte_wd,
  input  byte_idx_t                r8_sel,
  input  byte_idx_t                rp_sel,
  input  byte_idx_t                mem_sel,
  output data_t                    r8_q,
  output logic [2*DW-1:0]          rp_q,
  output data_t                    mem_q
);
  logic [NBYTE-1:0][DW-1:0] q;

  for (genvar i = 0; i < NBYTE; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)             q[i] <= '0;
      else if (byte_we[i]) q[i] <= byte_wd[i];
    end
  end

  assign r8_q  = q[r8_sel];
  assign rp_q  = {q[{rp_sel[BYTE_W-1:1], 1'b1}], q[rp_sel]};
  assign mem_q = q[mem_sel];
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
  import gpr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEE0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_load,
  input  logic [BANK_W-1:0]   bank_in,
  output logic [BANK_W-1:0]   active_bank,
  input  logic [REG_W-1:0]    r8_idx,
  input  logic                r8_we,
  input  logic [DW-1:0]       r8_wdata,
  output logic [DW-1:0]       r8_rdata,
  input  logic [PAIR_W-1:0]   rp_idx,
  input  logic                rp_we,
  input  logic [2*DW-1:0]     rp_wdata,
  output logic [2*DW-1:0]     rp_rdata,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_we,
  input  logic [DW-1:0]       mem_wdata,
  output logic [DW-1:0]       mem_rdata,
  output logic                mem_hit
);
  bank_t     bank_q;
  byte_idx_t r8_tgt, rp_tgt, mem_tgt;
  data_t     mem_raw;
  logic      collide_rm, collide_rp;
  logic [NBYTE-1:0]         byte_we;
  logic [NBYTE-1:0][DW-1:0] byte_wd;

  always_ff @(posedge clk) begin
    if (rst)            bank_q <= '0;
    else if (bank_load) bank_q <= bank_in;
  end

  assign active_bank = bank_q;
  assign r8_tgt      = flat_idx(bank_q, r8_idx);
  assign rp_tgt      = pair_lo(bank_q, rp_idx);

  gpr_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (mem_addr),
    .hit  (mem_hit),
    .idx  (mem_tgt)
  );

  gpr_write_arb u_arb (
    .r8_tgt     (r8_tgt),
    .r8_we      (r8_we),
    .r8_wdata   (r8_wdata),
    .rp_tgt     (rp_tgt),
    .rp_we      (rp_we),
    .rp_wdata   (rp_wdata),
    .mem_tgt    (mem_tgt),
    .mem_we     (mem_we),
    .mem_hit    (mem_hit),
    .mem_wdata  (mem_wdata),
    .byte_we    (byte_we),
    .byte_wd    (byte_wd),
    .collide_rm (collide_rm),
    .collide_rp (collide_rp)
  );

  gpr_store u_store (
    .clk     (clk),
    .rst     (rst),
    .byte_we (byte_we),
    .byte_wd (byte_wd),
    .r8_sel  (r8_tgt),
    .rp_sel  (rp_tgt),
    .mem_sel (mem_tgt),
    .r8_q    (r8_rdata),
    .rp_q    (rp_rdata),
    .mem_q   (mem_raw)
  );

  assign mem_rdata = mem_hit ? mem_raw : '0;
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker
  import gpr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEE0
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] active_bank,
  input logic [REG_W-1:0]  r8_idx,
  input logic              r8_we,
  input logic [DW-1:0]     r8_wdata,
  input logic [DW-1:0]     r8_rdata,
  input logic [PAIR_W-1:0] rp_idx,
  input logic              rp_we,
  input logic [2*DW-1:0]   rp_wdata,
  input logic [2*DW-1:0]   rp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_hit,
  input logic [DW-1:0]     mem_rdata,
  input logic              collide_rm,
  input logic              collide_rp
);
  logic started = 1'b0;
  logic [BYTE_W-1:0] rel;

  always_ff @(posedge clk) if (rst) started <= 1'b1;
  assign rel = BYTE_W'(mem_addr - WIN_BASE);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (active_bank == '0 && r8_rdata == '0 && rp_rdata == '0));

  p_byte_write_r2: assert property (@(posedge clk) disable iff (rst)
    (started && r8_we) |=>
      (!(r8_idx == $past(r8_idx) && active_bank == $past(active_bank))
       || r8_rdata == $past(r8_wdata)));

  p_pair_view_r3: assert property (@(posedge clk) disable iff (rst)
    (started && r8_idx[REG_W-1:1] == rp_idx) |->
      ((r8_idx[0] ? rp_rdata[2*DW-1:DW] : rp_rdata[DW-1:0]) == r8_rdata));

  p_pair_write_r4: assert property (@(posedge clk) disable iff (rst)
    (started && rp_we && !r8_we) |=>
      (!(rp_idx == $past(rp_idx) && active_bank == $past(active_bank))
       || rp_rdata == $past(rp_wdata)));

  p_outside_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (started && !mem_hit) |-> (mem_rdata == '0));

  p_alias_r7: assert property (@(posedge clk) disable iff (rst)
    (started && mem_hit && rel[BYTE_W-1:REG_W] == ~active_bank
     && rel[REG_W-1:0] == r8_idx) |-> (mem_rdata == r8_rdata));

  p_cpu_beats_mem_r9: assert property (@(posedge clk) disable iff (rst)
    (started && collide_rm) |=>
      (mem_addr != $past(mem_addr) || mem_rdata == $past(r8_wdata)));

  p_byte_beats_pair_r10: assert property (@(posedge clk) disable iff (rst)
    (started && collide_rp) |=>
      (!(r8_idx == $past(r8_idx) && active_bank == $past(active_bank))
       || r8_rdata == $past(r8_wdata)));
endmodule

bind gpr_bank_file gpr_checker #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .active_bank (active_bank),
  .r8_idx      (r8_idx),
  .r8_we       (r8_we),
  .r8_wdata    (r8_wdata),
  .r8_rdata    (r8_rdata),
  .rp_idx      (rp_idx),
  .rp_we       (rp_we),
  .rp_wdata    (rp_wdata),
  .rp_rdata    (rp_rdata),
  .mem_addr    (mem_addr),
  .mem_hit     (mem_hit),
  .mem_rdata   (mem_rdata),
  .collide_rm  (collide_rm),
  .collide_rp  (collide_rp)
);

// File: tb/sim_gpr_bank_file.sv
`timescale 1ns/1ps
module sim_gpr_bank_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_load = 1'b0;
  logic [1:0]  bank_in = '0;
  logic [1:0]  active_bank;
  logic [2:0]  r8_idx = '0;
  logic        r8_we = 1'b0;
  logic [7:0]  r8_wdata = '0;
  logic [7:0]  r8_rdata;
  logic [1:0]  rp_idx = '0;
  logic        rp_we = 1'b0;
  logic [15:0] rp_wdata = '0;
  logic [15:0] rp_rdata;
  logic [15:0] mem_addr = '0;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_hit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int m [32];
  int eb = 0;

  always #2 clk = ~clk;

  gpr_bank_file u0 (
    .clk(clk), .rst(rst), .bank_load(bank_load), .bank_in(bank_in),
    .active_bank(active_bank), .r8_idx(r8_idx), .r8_we(r8_we),
    .r8_wdata(r8_wdata), .r8_rdata(r8_rdata), .rp_idx(rp_idx), .rp_we(rp_we),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_hit(mem_hit)
  );

  function automatic bit in_win(int a);
    return a >= 'hFEE0 && a <= 'hFEFF;
  endfunction

  // address -> flat byte: bank = 3 - slot, register = low three bits
  function automatic int a2i(int a);
    return (3 - ((a - 'hFEE0) / 8)) * 8 + (a % 8);
  endfunction

  function automatic int i2a(int b, int r);
    return 'hFEE0 + (3 - b) * 8 + r;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // one clock with any mix of writes; model applies low priority first
  task automatic cyc(bit w8, int r, int d8, bit wp, int p, int dp,
                     bit wm, int a, int dm);
    @(negedge clk);
    r8_we = w8; r8_idx = 3'(r); r8_wdata = 8'(d8);
    rp_we = wp; rp_idx = 2'(p); rp_wdata = 16'(dp);
    mem_we = wm; mem_addr = 16'(a); mem_wdata = 8'(dm);
    @(posedge clk);
    if (wm && in_win(a)) m[a2i(a)] = dm & 'hFF;
    if (wp) begin
      m[eb*8 + 2*p]     = dp & 'hFF;
      m[eb*8 + 2*p + 1] = (dp >> 8) & 'hFF;
    end
    if (w8) m[eb*8 + r] = d8 & 'hFF;
    #1;
    r8_we = 1'b0; rp_we = 1'b0; mem_we = 1'b0;
  endtask

  task automatic set_bank(int b);
    @(negedge clk);
    bank_load = 1'b1; bank_in = 2'(b);
    @(posedge clk);
    eb = b;
    #1 bank_load = 1'b0;
  endtask

  task automatic check_regs(string req);
    chk(req, "active_bank", int'(active_bank), eb);
    for (int r = 0; r < 8; r++) begin
      r8_idx = 3'(r); #1;
      chk(req, $sformatf("bank%0d r%0d", eb, r), int'(r8_rdata), m[eb*8 + r]);
    end
    for (int p = 0; p < 4; p++) begin
      rp_idx = 2'(p); #1;
      // R3: pair = {odd register, even register}
      chk("R3", $sformatf("bank%0d pair%0d", eb, p), int'(rp_rdata),
          m[eb*8 + 2*p + 1] * 256 + m[eb*8 + 2*p]);
    end
  endtask

  task automatic check_all(string req);
    for (int a = 'hFEE0; a <= 'hFEFF; a++) begin
      mem_addr = 16'(a); #1;
      chk(req, $sformatf("mem %0h", a), int'(mem_rdata), m[a2i(a)]);
      chk("R6", $sformatf("hit %0h", a), int'(mem_hit), 1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 32; i++) m[i] = 0;
    eb = 0;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    int outs [6];
    outs = '{'hFEDF, 'hFF00, 'h0000, 'hFFFF, 'h7EE0, 'hFEC0};
    do_reset();
    // R1: everything zero, bank 0
    check_regs("R1");
    check_all("R1");

    // R7: fill through the memory port, read through each bank
    for (int a = 'hFEE0; a <= 'hFEFF; a++)
      cyc(0, 0, 0, 0, 0, 0, 1, a, (a * 37 + 11) & 'hFF);
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      check_regs("R7");
    end
    check_all("R7");

    // R2 / R5: byte writes in every bank, new bank used right after load
    for (int b = 3; b >= 0; b--) begin
      set_bank(b);
      check_regs("R5");
      for (int r = 0; r < 8; r++) cyc(1, r, 'h80 + b * 16 + r, 0, 0, 0, 0, 0, 0);
      check_regs("R2");
    end
    check_all("R2");

    // R4: pair writes update both bytes
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int p = 0; p < 4; p++) cyc(0, 0, 0, 1, p, 'hA000 + b * 'h111 + p * 'h2B, 0, 0, 0);
      check_regs("R4");
    end
    check_all("R4");

    // R6 / R8: addresses outside the window
    foreach (outs[k]) begin
      mem_addr = 16'(outs[k]); #1;
      chk("R6", $sformatf("hit %0h", outs[k]), int'(mem_hit), 0);
      chk("R6", $sformatf("rdata %0h", outs[k]), int'(mem_rdata), 0);
      cyc(0, 0, 0, 0, 0, 0, 1, outs[k], 'h5A);
    end
    check_all("R8");

    // R9: byte port against memory port on the same byte, then different bytes
    set_bank(1);
    cyc(1, 3, 'h11, 0, 0, 0, 1, i2a(1, 3), 'h22);
    mem_addr = 16'(i2a(1, 3)); #1;
    chk("R9", "same byte", int'(mem_rdata), 'h11);
    cyc(1, 4, 'h33, 0, 0, 0, 1, i2a(3, 4), 'h44);
    cyc(0, 0, 0, 1, 1, 'h6677, 1, i2a(1, 2), 'h99);
    check_all("R9");
    check_regs("R9");

    // R10: byte port overlapping one half of a pair write
    set_bank(2);
    cyc(1, 5, 'h55, 1, 2, 'hBEEF, 0, 0, 0);
    r8_idx = 3'd4; #1;
    chk("R10", "pair low kept", int'(r8_rdata), 'hEF);
    r8_idx = 3'd5; #1;
    chk("R10", "byte wins", int'(r8_rdata), 'h55);
    cyc(1, 0, 'h0C, 1, 0, 'h1234, 1, i2a(2, 0), 'hFF);
    check_regs("R10");
    check_all("R10");

    // R1 again in mid-run
    set_bank(3);
    do_reset();
    check_regs("R1");
    check_all("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule